// File: doc/BRIEF.md
# I2C Register Target with Alert Response

This block is a byte-oriented I2C target that connects a two-wire management bus to the register file of a port controller. It watches SCL and SDA through synchronisers clocked by the system clock and finds START and STOP conditions. It shifts bits in and out and generates acknowledges. Each completed transfer becomes a single-cycle strobe on a simple synchronous register port.

Its 7-bit bus address has the fixed upper bits `010`, followed by four strap inputs. A write transfer carries a register pointer and one data byte. A combined transfer sets the pointer and then reads one byte after a repeated START. A bare read, with no pointer written since the last STOP, returns the interrupt status register. The block also answers the SMBus alert response address and returns its own strapped address.

SDA arrives on an input-only pin and leaves on a separate open-drain drive signal. Both can pass through opto-isolators and be joined outside the block to form the usual bidirectional line.

Top module: `i2c_regport_target`

## Requirements
- R1: The target responds only to the bus address `{3'b010, strap_addr[3:0]}`, sent MSB first and followed by the R/W bit (1 = read). It pulls SDA low in the acknowledge slot of each byte it accepts.
- R2: A write transfer is: address byte with R/W=0, pointer byte, data byte, STOP. It acknowledges all three bytes. It produces exactly one single-cycle `reg_wr` pulse, with `reg_addr` = pointer and `reg_wdata` = data.
- R3: A combined read is: address byte with R/W=0, pointer byte, repeated START, address byte with R/W=1. It acknowledges all three bytes, issues one single-cycle `reg_rd` at the pointer, and returns the addressed register byte MSB first.
- R4: A read addressed to the device with no pointer written since the last STOP returns the register at pointer `INT_PTR` (default 0x00), which is the interrupt status register.
- R5: An address byte of `0001100` with R/W=1 is acknowledged. The target then returns `{3'b010, strap_addr, 1'b1}`, and no register access is made.
- R6: An address byte that matches neither address gets no acknowledge. The target then keeps SDA released and makes no register access until the next START.
- R7: The SDA drive changes only while SCL is low.
- R8: While `rst` is high, SDA is released and `reg_wr` and `reg_rd` are low.
- R9: A STOP forgets the pointer. A later bare read again returns register `INT_PTR`.
- R10: A byte sent after the data byte of a write is not acknowledged and does not write any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_addr | input | 4 | Low four bits of the bus address |
| scl_in | input | 1 | Bus clock from the line |
| sda_in | input | 1 | Bus data from the line |
| sda_drive_low | output | 1 | 1 pulls SDA low (open-drain drive) |
| reg_addr | output | 8 | Register pointer for the access |
| reg_wdata | output | 8 | Write data |
| reg_wr | output | 1 | Single-cycle write strobe |
| reg_rd | output | 1 | Single-cycle read strobe |
| reg_rdata | input | 8 | Read data, valid the cycle after `reg_rd` |

## Verification
A bit-banged master on the bench drives transfers against a bench register model. Directed writes, combined reads and bare reads separate the pointer path from the interrupt-register default, including a bare read just after a STOP. Alert-response reads with several strap values show that the reply is built from the straps. Writes and reads at foreign addresses, and an overlong write, show that non-accepted bytes give no acknowledge and no register access. Random mixes of all five transfer kinds under changing straps catch state left over from one transfer into the next. A port-level monitor watches SDA edges against SCL throughout.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;
  localparam int BYTE_W = 8;
  localparam logic [2:0] DEV_FIXED_HI    = 3'b010;
  localparam logic [6:0] ALERT_RESP_ADDR = 7'b0001100;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_W,
    ST_PTR,
    ST_ACK_PTR,
    ST_DATA,
    ST_ACK_DATA,
    ST_ACK_RD,
    ST_TX,
    ST_MACK,
    ST_IGNORE
  } st_e;
endpackage

// File: rtl/i2cr_bus_sync.sv
module i2cr_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_raw};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_raw};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  // SDA edges while SCL stays high frame a transfer
  assign bus_start = scl_s & scl_d & sda_d & ~sda_s;
  assign bus_stop  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2cr_addr_match.sv
module i2cr_addr_match
  import i2cr_pkg::*;
(
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [3:0]        strap,
  output logic              dev_hit,
  output logic              alert_hit,
  output logic              rnw,
  output logic [BYTE_W-1:0] alert_reply
);
  logic [6:0] own_addr;

  assign own_addr    = {DEV_FIXED_HI, strap};
  assign rnw         = rx_byte[0];
  assign dev_hit     = (rx_byte[7:1] == own_addr);
  assign alert_hit   = (rx_byte[7:1] == ALERT_RESP_ADDR) && rx_byte[0];
  assign alert_reply = {own_addr, 1'b1};
endmodule

// File: rtl/i2cr_proto_fsm.sv
module i2cr_proto_fsm
  import i2cr_pkg::*;
#(
  parameter int              PTR_W  = 8,
  parameter logic [PTR_W-1:0] INT_PTR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              dev_hit,
  input  logic              alert_hit,
  input  logic              rnw,
  input  logic [BYTE_W-1:0] alert_reply,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              sda_low,
  output logic [PTR_W-1:0]  reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_wr,
  output logic              reg_rd,
  input  logic [BYTE_W-1:0] reg_rdata
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);

  st_e              state;
  logic [CNT_W-1:0] bit_cnt;
  logic [BYTE_W-1:0] tx;
  logic [PTR_W-1:0] ptr;
  logic             ptr_valid;
  logic             rd_cap;
  logic             rx_state;
  logic             byte_done;

  assign rx_state  = (state == ST_ADDR) || (state == ST_PTR) || (state == ST_DATA);
  assign byte_done = scl_fall && (bit_cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bit_cnt   <= '0;
      rx_byte   <= '0;
      tx        <= '1;
      ptr       <= '0;
      ptr_valid <= 1'b0;
      sda_low   <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      reg_wr    <= 1'b0;
      reg_rd    <= 1'b0;
      rd_cap    <= 1'b0;
    end else begin
      reg_wr <= 1'b0;
      reg_rd <= 1'b0;
      rd_cap <= reg_rd;
      if (rd_cap) tx <= reg_rdata;

      if (bus_start) begin
        state   <= ST_ADDR;
        bit_cnt <= '0;
        sda_low <= 1'b0;
      end else if (bus_stop) begin
        state     <= ST_IDLE;
        ptr_valid <= 1'b0;
        sda_low   <= 1'b0;
      end else begin
        if (scl_rise && rx_state && bit_cnt != LAST) begin
          rx_byte <= {rx_byte[BYTE_W-2:0], sda_s};
          bit_cnt <= bit_cnt + 1'b1;
        end
        unique case (state)
          ST_ADDR: if (byte_done) begin
            if (dev_hit && !rnw) begin
              sda_low <= 1'b1;
              state   <= ST_ACK_W;
            end else if (dev_hit) begin
              sda_low  <= 1'b1;
              reg_addr <= ptr_valid ? ptr : INT_PTR;
              reg_rd   <= 1'b1;
              state    <= ST_ACK_RD;
            end else if (alert_hit) begin
              sda_low <= 1'b1;
              tx      <= alert_reply;
              state   <= ST_ACK_RD;
            end else begin
              state <= ST_IGNORE;
            end
          end
          ST_ACK_W: if (scl_fall) begin
            sda_low <= 1'b0;
            bit_cnt <= '0;
            state   <= ST_PTR;
          end
          ST_PTR: if (byte_done) begin
            ptr       <= rx_byte;
            ptr_valid <= 1'b1;
            sda_low   <= 1'b1;
            state     <= ST_ACK_PTR;
          end
          ST_ACK_PTR: if (scl_fall) begin
            sda_low <= 1'b0;
            bit_cnt <= '0;
            state   <= ST_DATA;
          end
          ST_DATA: if (byte_done) begin
            reg_addr  <= ptr;
            reg_wdata <= rx_byte;
            reg_wr    <= 1'b1;
            sda_low   <= 1'b1;
            state     <= ST_ACK_DATA;
          end
          ST_ACK_DATA: if (scl_fall) begin
            sda_low <= 1'b0;
            state   <= ST_IGNORE;
          end
          ST_ACK_RD: if (scl_fall) begin
            sda_low <= ~tx[BYTE_W-1];
            tx      <= {tx[BYTE_W-2:0], 1'b1};
            bit_cnt <= CNT_W'(1);
            state   <= ST_TX;
          end
          ST_TX: if (scl_fall) begin
            if (bit_cnt == LAST) begin
              sda_low <= 1'b0;
              state   <= ST_MACK;
            end else begin
              sda_low <= ~tx[BYTE_W-1];
              tx      <= {tx[BYTE_W-2:0], 1'b1};
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
          ST_MACK: if (scl_rise) state <= ST_IGNORE;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_regport_target.sv
module i2c_regport_target
  import i2cr_pkg::*;
#(
  parameter int               SYNC_STAGES = 2,
  parameter int               PTR_W       = 8,
  parameter logic [PTR_W-1:0] INT_PTR     = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        strap_addr,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_drive_low,
  output logic [PTR_W-1:0]  reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_wr,
  output logic              reg_rd,
  input  logic [BYTE_W-1:0] reg_rdata
);
  logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  logic dev_hit, alert_hit, rnw;
  logic [BYTE_W-1:0] rx_byte, alert_reply;

  i2cr_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_raw(scl_in), .sda_raw(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop)
  );

  i2cr_addr_match u_match (
    .rx_byte(rx_byte), .strap(strap_addr), .dev_hit(dev_hit),
    .alert_hit(alert_hit), .rnw(rnw), .alert_reply(alert_reply)
  );

  i2cr_proto_fsm #(.PTR_W(PTR_W), .INT_PTR(INT_PTR)) u_fsm (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop), .dev_hit(dev_hit),
    .alert_hit(alert_hit), .rnw(rnw), .alert_reply(alert_reply),
    .rx_byte(rx_byte), .sda_low(sda_drive_low), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );
endmodule

// File: rtl/i2cr_checker.sv
module i2cr_checker (
  input logic clk,
  input logic rst,
  input logic scl_s,
  input logic bus_stop,
  input logic sda_drive_low,
  input logic reg_wr,
  input logic reg_rd
);
  p_sda_edge_scl_low_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_drive_low) |-> !$past(scl_s));

  p_wr_single_r2: assert property (@(posedge clk) disable iff (rst)
    reg_wr |=> !reg_wr);

  p_rd_single_r3: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> !reg_rd);

  p_wr_rd_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && reg_rd));

  p_stop_release_r6: assert property (@(posedge clk) disable iff (rst)
    bus_stop |=> !sda_drive_low);

  p_reset_quiet_r8: assert property (@(posedge clk)
    rst |=> (!sda_drive_low && !reg_wr && !reg_rd));
endmodule

bind i2c_regport_target i2cr_checker u_chk (
  .clk(clk), .rst(rst), .scl_s(scl_s), .bus_stop(bus_stop),
  .sda_drive_low(sda_drive_low), .reg_wr(reg_wr), .reg_rd(reg_rd)
);

// File: tb/i2c_regport_target_tb.sv
module i2c_regport_target_tb_top;
  localparam int H = 12;
  localparam logic [7:0] INT_PTR = 8'h00;
  localparam logic [6:0] ALERT = 7'b0001100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] strap = 4'h0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_drive_low, reg_wr, reg_rd;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic sda_line;

  int checks = 0, errors = 0;
  int wr_count = 0, scl_high_edges = 0;
  logic [7:0] mem [256];
  logic [7:0] model [256];
  logic prev_drv = 1'b0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign sda_line = m_sda & ~sda_drive_low;

  i2c_regport_target dut_i (
    .clk(clk), .rst(rst), .strap_addr(strap), .scl_in(m_scl), .sda_in(sda_line),
    .sda_drive_low(sda_drive_low), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  initial for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;

  always @(posedge clk) begin
    if (reg_wr) begin
      mem[reg_addr] <= reg_wdata;
      wr_count <= wr_count + 1;
    end
    if (reg_rd) reg_rdata <= mem[reg_addr];
    if (!rst && sda_drive_low != prev_drv && m_scl) scl_high_edges <= scl_high_edges + 1;
    prev_drv <= sda_drive_low;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(H); m_scl = 1'b1; tick(H);
    m_sda = 1'b0; tick(H); m_scl = 1'b0; tick(H);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(H); m_scl = 1'b1; tick(H);
    m_sda = 1'b1; tick(H);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tick(H); m_scl = 1'b1; tick(H); m_scl = 1'b0;
    end
    m_sda = 1'b1; tick(H); m_scl = 1'b1; tick(H / 2);
    ack = ~sda_line; tick(H / 2); m_scl = 1'b0; tick(2);
  endtask

  task automatic get_byte(output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(H); m_scl = 1'b1; tick(H / 2); b[i] = sda_line; tick(H / 2); m_scl = 1'b0;
    end
    tick(H); m_scl = 1'b1; tick(H); m_scl = 1'b0; tick(2);
  endtask

  function automatic logic [6:0] own();
    return {3'b010, strap};
  endfunction

  task automatic do_write(input logic [6:0] dev, input logic [7:0] p, input logic [7:0] d,
                          input bit extra, output logic [3:0] acks);
    logic a0, a1, a2, a3;
    bus_start(); put_byte({dev, 1'b0}, a0); put_byte(p, a1); put_byte(d, a2);
    a3 = 1'b0;
    if (extra) put_byte(~d, a3);
    bus_stop();
    acks = {a3, a2, a1, a0};
    if (dev == own()) model[p] = d;
  endtask

  task automatic do_read(input logic [6:0] dev, input logic [7:0] p,
                         output logic [2:0] acks, output logic [7:0] d);
    logic a0, a1, a2;
    bus_start(); put_byte({dev, 1'b0}, a0); put_byte(p, a1);
    bus_start(); put_byte({dev, 1'b1}, a2); get_byte(d); bus_stop();
    acks = {a2, a1, a0};
  endtask

  task automatic do_bare(input logic [6:0] dev, output logic ack, output logic [7:0] d);
    bus_start(); put_byte({dev, 1'b1}, ack); get_byte(d); bus_stop();
  endtask

  initial begin
    logic [3:0] acks4;
    logic [2:0] acks3;
    logic a;
    logic [7:0] d;
    int wc, dummy;
    for (int i = 0; i < 256; i++) model[i] = 8'(i) ^ 8'h5A;
    dummy = $urandom(32'h1F2E3D);
    tick(6);
    // R8: quiet during reset
    check("R8 sda", sda_drive_low, 0);
    check("R8 strobes", {reg_wr, reg_rd}, 0);
    rst = 1'b0; tick(6);

    strap = 4'h3;
    do_write(own(), 8'h10, 8'hC3, 0, acks4);
    check("R2 acks", acks4, 4'b0111);
    check("R2 mem", mem[8'h10], 8'hC3);
    do_read(own(), 8'h10, acks3, d);
    check("R3 acks", acks3, 3'b111);
    check("R3 data", d, 8'hC3);
    do_write(own(), INT_PTR, 8'hA5, 0, acks4);
    do_bare(own(), a, d);
    check("R4 ack", a, 1);
    check("R4 data", d, 8'hA5);
    // R9: pointer from a finished transfer is forgotten
    do_write(own(), 8'h22, 8'h7E, 0, acks4);
    do_bare(own(), a, d);
    check("R9 data", d, model[INT_PTR]);
    // R5 with two straps
    do_bare(ALERT, a, d);
    check("R5 ack", a, 1);
    check("R5 reply", d, {3'b010, strap, 1'b1});
    strap = 4'hC;
    do_bare(ALERT, a, d);
    check("R5 reply strapC", d, {3'b010, strap, 1'b1});
    // R6: foreign address
    wc = wr_count;
    do_write({3'b011, strap}, 8'h30, 8'h11, 0, acks4);
    check("R6 acks", acks4, 0);
    check("R6 no write", wr_count, wc);
    do_bare({3'b010, ~strap}, a, d);
    check("R6 read nack", a, 0);
    check("R6 released", d, 8'hFF);
    // R10: extra byte after data
    wc = wr_count;
    do_write(own(), 8'h40, 8'h3C, 1, acks4);
    check("R10 acks", acks4, 4'b0111);
    check("R10 one write", wr_count, wc + 1);
    check("R10 next untouched", mem[8'h41], model[8'h41]);
    // R1: strap sets address, random mix
    for (int it = 0; it < 30; it++) begin
      logic [7:0] p, v;
      strap = 4'($urandom);
      p = 8'($urandom); v = 8'($urandom);
      case ($urandom % 5)
        0: begin do_write(own(), p, v, 0, acks4); check("R1 wr acks", acks4, 4'b0111); end
        1: begin do_read(own(), p, acks3, d); check("R3 rnd data", d, model[p]); end
        2: begin do_bare(own(), a, d); check("R4 rnd data", d, model[INT_PTR]); end
        3: begin do_bare(ALERT, a, d); check("R5 rnd reply", d, {3'b010, strap, 1'b1}); end
        default: begin
          wc = wr_count;
          do_write({~strap[3], 2'b01, strap}, p, v, 0, acks4);
          check("R1 foreign acks", acks4, 0);
          check("R6 rnd no write", wr_count, wc);
        end
      endcase
    end
    check("R7 sda edges with scl high", scl_high_edges, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule